// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Status

This block recovers asynchronous serial characters from a line that idles high. It is paced by a one-cycle oversampling tick from an external baud generator. Each bit lasts `OVS` ticks. The receiver confirms a start bit at its middle and samples every later bit at the middle as well. It shifts the data least-significant bit first and checks the optional parity bit and one or two stop bits. A finished character is presented on a valid/ready output, where it waits to be written into a downstream receive FIFO.

The receiver reads an 8-bit format control byte. This is the same byte that sets up the companion transmitter. The byte gives the data length, the parity kind and the stop-bit count. An 8-bit status byte reports line faults as sticky flags, which a read strobe clears. It also carries a live indication of a break in progress. A loopback select feeds the receiver from the transmitter's internal line instead of the pin. In half-duplex operation the line is ignored while the transmitter reports itself busy.

Top module: `uart_rx_status`

## Requirements
- R1: Format bits [3:0] select the data length: 4'b0111 gives 7 bits, 4'b1000 gives 8 bits, 4'b1001 gives 9 bits, and any other code is taken as 8. Data arrives LSB first and appears right-aligned on `rx_data_o`, with the unused upper bits zero. `rx_valid_o` stays high, with the data unchanged, until `rx_ready_i` is sampled high.
- R2: Format bits [6:4] select parity: 0 none, 1 odd, 2 even, 3 always 1, 4 always 0, and 5 to 7 none. A mismatch sets status bit 5, and the character is still delivered. With 9 data bits no parity bit is expected, whatever these bits hold.
- R3: Format bit 7 selects one stop bit (0) or two (1). Every stop bit checked must be high. Otherwise status bit 4 is set, the character is still delivered, and the receiver waits for the line to go high before looking for a new start bit.
- R4: A frame whose start bit, data bits, parity bit and first stop bit are all sampled low is a break. It sets status bit 3, which is latched, and status bit 7, which is live. No character is delivered. Bit 7 falls when the line is next sampled high. Bit 3 stays set until it is read.
- R5: If a character completes while `fifo_full_i` is high, or while the previous character is still waiting to be accepted, status bit 6 is set. That character is discarded and the waiting character is left as it was.
- R6: A pulse on `status_rd_i` clears status bits 3 to 6 on the next cycle. An event in the same cycle wins over the clear. Bit 7 is not affected by reads, and bits 2 to 0 always read 0.
- R7: A start bit is accepted only if the line is still low half a bit after the falling edge. A low pulse shorter than half a bit delivers nothing and sets no flag.
- R8: While `half_duplex_i` and `tx_busy_i` are both high, the receiver treats its line as high.
- R9: While `loop_en_i` is high, the receiver takes its line from `tx_line_i` and `rx_i` has no effect.
- R10: After reset `rx_valid_o` is 0 and `status_o` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, `OVS` per bit |
| fmt_i | input | 8 | Character format control byte |
| loop_en_i | input | 1 | Take the line from the transmitter |
| half_duplex_i | input | 1 | Ignore the line while transmitting |
| rx_i | input | 1 | Serial input pin |
| tx_line_i | input | 1 | Transmitter serial output, used in loopback |
| tx_busy_i | input | 1 | Transmitter is sending |
| rx_data_o | output | 9 | Received character, right-aligned |
| rx_valid_o | output | 1 | Character waiting |
| rx_ready_i | input | 1 | Downstream accepts the character |
| fifo_full_i | input | 1 | Downstream receive FIFO is full |
| status_rd_i | input | 1 | Status read strobe, clears the sticky flags |
| status_o | output | 8 | Error status byte |

## Verification
The bench builds the receiver with `OVS` = 8 and two synchronizer stages, and it drives the tick high on every clock. One bit therefore lasts eight cycles, so a full 12-bit frame with two stop bits fits in about a hundred cycles. A three-cycle low pulse is a real sub-half-bit glitch against a four-tick start check. These short bits let one run cover every data length and every parity kind. They also bring into reach a break held past a whole frame and both causes of overrun, each followed by its status read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W   = 9;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned FLAG_LSB = 3;  // sticky flags: break, framing, parity, overrun
  localparam int unsigned NFLAG    = 4;
  localparam int unsigned LIVE_BIT = 7;

  localparam logic [2:0] PM_ODD   = 3'd1;
  localparam logic [2:0] PM_EVEN  = 3'd2;
  localparam logic [2:0] PM_MARK  = 3'd3;
  localparam logic [2:0] PM_SPACE = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic [2:0] pmode;
    logic       two_stop;
  } fmt_t;

  function automatic fmt_t fmt_decode(input logic [7:0] raw);
    fmt_t f;
    f.nbits    = (raw[3:0] == 4'd7 || raw[3:0] == 4'd9) ? raw[3:0] : 4'd8;
    f.pmode    = raw[6:4];
    f.par_en   = (f.nbits != 4'd9) && (raw[6:4] >= PM_ODD) && (raw[6:4] <= PM_SPACE);
    f.two_stop = raw[7];
    return f;
  endfunction
endpackage

// File: rtl/uart_rx_line_sel.sv
module uart_rx_line_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tx_line_i,
  input  logic loop_en_i,
  input  logic half_duplex_i,
  input  logic tx_busy_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic src;

  assign src = loop_en_i ? tx_line_i : rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], src};
  end

  // own transmission masked in half-duplex
  assign line_o = (half_duplex_i && tx_busy_i) ? 1'b1 : sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic [7:0]        fmt_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o,
  output logic              brk_live_o
);
  localparam int unsigned CW   = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int unsigned HALF = OVS / 2;

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [3:0]        bit_q;
  logic [DATA_W-1:0] shreg_q;
  logic              all_low_q, par_bit_q, stop2_q, frm_q, live_q, done_q, brk_q;
  fmt_t              fmt_q;
  logic              bit_end, ones, stop_bad;

  assign bit_end  = (cnt_q == CW'(OVS - 1));
  assign stop_bad = frm_q | ~line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shreg_q   <= '0;
      all_low_q <= 1'b0;
      par_bit_q <= 1'b0;
      stop2_q   <= 1'b0;
      frm_q     <= 1'b0;
      live_q    <= 1'b0;
      done_q    <= 1'b0;
      brk_q     <= 1'b0;
      fmt_q     <= '0;
    end else begin
      done_q <= 1'b0;
      brk_q  <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!line_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: if (cnt_q == CW'(HALF - 1)) begin
            if (!line_i) begin
              state_q   <= ST_DATA;
              cnt_q     <= '0;
              bit_q     <= '0;
              all_low_q <= 1'b1;
              stop2_q   <= 1'b0;
              frm_q     <= 1'b0;
              fmt_q     <= fmt_decode(fmt_i);
            end else begin
              state_q <= ST_IDLE;  // glitch
            end
          end else cnt_q <= cnt_q + 1'b1;
          ST_DATA: if (bit_end) begin
            cnt_q     <= '0;
            shreg_q   <= {line_i, shreg_q[DATA_W-1:1]};
            all_low_q <= all_low_q & ~line_i;
            if (bit_q == fmt_q.nbits - 4'd1) state_q <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else                             bit_q   <= bit_q + 4'd1;
          end else cnt_q <= cnt_q + 1'b1;
          ST_PAR: if (bit_end) begin
            cnt_q     <= '0;
            par_bit_q <= line_i;
            all_low_q <= all_low_q & ~line_i;
            state_q   <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          ST_STOP: if (bit_end) begin
            cnt_q <= '0;
            if (!stop2_q && !line_i && all_low_q) begin
              brk_q   <= 1'b1;
              live_q  <= 1'b1;
              state_q <= ST_HOLD;
            end else if (stop2_q || !fmt_q.two_stop) begin
              done_q  <= 1'b1;
              frm_q   <= stop_bad;
              state_q <= stop_bad ? ST_HOLD : ST_IDLE;
            end else begin
              stop2_q <= 1'b1;
              frm_q   <= stop_bad;
            end
          end else cnt_q <= cnt_q + 1'b1;
          ST_HOLD: if (line_i) begin
            state_q <= ST_IDLE;
            live_q  <= 1'b0;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign data_o = shreg_q >> (4'(DATA_W) - fmt_q.nbits);
  assign ones   = ^data_o;

  always_comb begin
    case (fmt_q.pmode)
      PM_ODD:   par_err_o = ~(ones ^ par_bit_q);
      PM_EVEN:  par_err_o = ones ^ par_bit_q;
      PM_MARK:  par_err_o = ~par_bit_q;
      PM_SPACE: par_err_o = par_bit_q;
      default:  par_err_o = 1'b0;
    endcase
    par_err_o = par_err_o & fmt_q.par_en;
  end

  assign done_o     = done_q;
  assign frm_err_o  = frm_q;
  assign brk_o      = brk_q;
  assign brk_live_o = live_q;
endmodule

// File: rtl/uart_rx_err_flags.sv
module uart_rx_err_flags
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [NFLAG-1:0]  set_i,
  input  logic              live_i,
  output logic [STAT_W-1:0] status_o
);
  logic [NFLAG-1:0] flag_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= set_i[i] | (flag_q[i] & ~rd_i);  // set beats clear
    end
  end

  always_comb begin
    status_o                    = '0;
    status_o[FLAG_LSB +: NFLAG] = flag_q;
    status_o[LIVE_BIT]          = live_i;
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [7:0]        fmt_i,
  input  logic              loop_en_i,
  input  logic              half_duplex_i,
  input  logic              rx_i,
  input  logic              tx_line_i,
  input  logic              tx_busy_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic              fifo_full_i,
  input  logic              status_rd_i,
  output logic [STAT_W-1:0] status_o
);
  logic              line, frame_done, par_err, frm_err, brk_pulse, brk_live, ovr_ev;
  logic [DATA_W-1:0] frame_data, data_q;
  logic              valid_q;
  logic [NFLAG-1:0]  flag_set;

  uart_rx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk_i, .rst_ni, .rx_i, .tx_line_i, .loop_en_i, .half_duplex_i, .tx_busy_i,
    .line_o(line)
  );

  uart_rx_framer #(.OVS(OVS)) u_framer (
    .clk_i, .rst_ni, .tick_i, .line_i(line), .fmt_i,
    .done_o(frame_done), .data_o(frame_data), .par_err_o(par_err),
    .frm_err_o(frm_err), .brk_o(brk_pulse), .brk_live_o(brk_live)
  );

  assign ovr_ev = frame_done & (fifo_full_i | (valid_q & ~rx_ready_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (frame_done && !ovr_ev) begin
      valid_q <= 1'b1;
      data_q  <= frame_data;
    end else if (valid_q && rx_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign flag_set = {ovr_ev, frame_done & par_err, frame_done & frm_err, brk_pulse};

  uart_rx_err_flags u_flags (
    .clk_i, .rst_ni, .rd_i(status_rd_i), .set_i(flag_set), .live_i(brk_live),
    .status_o
  );

  assign rx_data_o  = data_q;
  assign rx_valid_o = valid_q;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk
  import uart_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              status_rd_i,
  input logic [STAT_W-1:0] status_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              fifo_full_i,
  input logic              done_i,
  input logic              frm_set_i,
  input logic              brk_set_i
);
  assert_rsvd_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2:0] == 3'b000);

  assert_rd_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i && !frm_set_i |=> !status_o[4]);

  assert_hold_char_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));

  assert_ovr_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && fifo_full_i |=> status_o[6] && !$rose(rx_valid_o));

  assert_frm_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4] && !status_rd_i |=> status_o[4]);

  assert_brk_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_set_i |=> status_o[3]);
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_rd_i(status_rd_i), .status_o(status_o),
  .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o),
  .fifo_full_i(fifo_full_i), .done_i(frame_done), .frm_set_i(flag_set[1]),
  .brk_set_i(brk_pulse)
);

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  localparam int unsigned OVS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fmt = 8'h08;
  logic       loop_en = 1'b0, hd = 1'b0, rx = 1'b1, tx_line = 1'b1, tx_busy = 1'b0;
  logic       rx_ready = 1'b0, fifo_full = 1'b0, st_rd = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic [7:0] status;

  int total = 0;
  int bad   = 0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  uart_rx_status #(.OVS(OVS), .SYNC_STAGES(2)) u_uart_rx_status (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .fmt_i(fmt), .loop_en_i(loop_en),
    .half_duplex_i(hd), .rx_i(rx), .tx_line_i(tx_line), .tx_busy_i(tx_busy),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .fifo_full_i(fifo_full), .status_rd_i(st_rd), .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock model comparison: a waiting character must match the model queue head
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected char", {23'd0, rx_data}, 32'hxxxx);
      else chk(rx_data == exp_q[0], "R1 char data", {23'd0, rx_data}, {23'd0, exp_q[0]});
    end
    if (rst_n) chk(status[2:0] == 3'b000, "R6 reserved bits", {29'd0, status[2:0]}, 0);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input bit on_tx, input logic v);
    if (on_tx) tx_line = v; else rx = v;
    idle(OVS);
  endtask

  task automatic send(input bit on_tx, input logic [8:0] d, input int nb, input int pm,
                      input bit two, input bit bad_par, input bit bad_s1, input bit bad_s2,
                      input bit deliver);
    logic ones;
    fmt = {two, 3'(pm), 4'(nb)};
    if (deliver) exp_q.push_back(d);
    put_bit(on_tx, 1'b0);
    ones = 1'b0;
    for (int i = 0; i < nb; i++) begin
      put_bit(on_tx, d[i]);
      ones = ones ^ d[i];
    end
    if (nb != 9 && pm >= 1 && pm <= 4) begin
      logic p;
      p = (pm == 1) ? ~ones : (pm == 2) ? ones : (pm == 3) ? 1'b1 : 1'b0;
      put_bit(on_tx, p ^ bad_par);
    end
    put_bit(on_tx, ~bad_s1);
    if (two) put_bit(on_tx, ~bad_s2);
    if (on_tx) tx_line = 1'b1; else rx = 1'b1;
    idle(3 * OVS);
  endtask

  task automatic take_char(input logic [8:0] d, input string req);
    chk(rx_valid == 1'b1 && rx_data == d, req, {22'd0, rx_valid, rx_data}, {22'd1, d});
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    void'(exp_q.pop_front());
    chk(rx_valid == 1'b0, {req, " valid drop"}, {31'd0, rx_valid}, 0);
  endtask

  task automatic no_char(input string req);
    chk(rx_valid == 1'b0, req, {31'd0, rx_valid}, 0);
  endtask

  task automatic read_status(input logic [7:0] exp, input string req);
    chk(status == exp, req, {24'd0, status}, {24'd0, exp});
    st_rd = 1'b1;
    @(negedge clk);
    st_rd = 1'b0;
    chk(status == (exp & 8'h80), {req, " after read"}, {24'd0, status}, {24'd0, exp & 8'h80});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(rx_valid == 1'b0 && status == 8'h00, "R10 reset", {23'd0, rx_valid, status}, 0);

    // R1 formats
    send(0, 9'h0A5, 8, 0, 0, 0, 0, 0, 1); take_char(9'h0A5, "R1 8N1");
    send(0, 9'h05A, 7, 0, 0, 0, 0, 0, 1); take_char(9'h05A, "R1 7N1 upper bits zero");
    // R2 parity kinds
    send(0, 9'h03C, 8, 1, 0, 0, 0, 0, 1); take_char(9'h03C, "R2 odd");
    send(0, 9'h05B, 7, 2, 0, 0, 0, 0, 1); take_char(9'h05B, "R2 even");
    send(0, 9'h011, 8, 3, 0, 0, 0, 0, 1); take_char(9'h011, "R2 mark");
    send(0, 9'h0F0, 8, 4, 0, 0, 0, 0, 1); take_char(9'h0F0, "R2 space");
    read_status(8'h00, "R2 clean parity");
    send(0, 9'h05A, 7, 2, 0, 1, 0, 0, 1); take_char(9'h05A, "R2 bad parity char kept");
    read_status(8'h20, "R2 parity flag");
    send(0, 9'h1C3, 9, 2, 0, 0, 0, 0, 1); take_char(9'h1C3, "R2 9-bit ignores parity");
    read_status(8'h00, "R2 9-bit no parity bit");
    // R3 stop bits
    send(0, 9'h066, 8, 0, 1, 0, 0, 0, 1); take_char(9'h066, "R3 two stops");
    read_status(8'h00, "R3 two stops clean");
    send(0, 9'h067, 8, 0, 1, 0, 0, 1, 1); take_char(9'h067, "R3 second stop low");
    read_status(8'h10, "R3 framing flag");
    send(0, 9'h068, 8, 0, 0, 0, 1, 0, 1); take_char(9'h068, "R3 single stop low");
    read_status(8'h10, "R3 framing flag 1 stop");
    // R4 break
    fmt = 8'h08;
    rx = 1'b0;
    idle(13 * OVS);
    no_char("R4 no char on break");
    chk(status == 8'h88, "R4 break latched and live", {24'd0, status}, 32'h88);
    rx = 1'b1;
    idle(3 * OVS);
    chk(status == 8'h08, "R4 live clears on high", {24'd0, status}, 32'h08);
    read_status(8'h08, "R4 latched clears on read");
    // R5 overrun
    fifo_full = 1'b1;
    send(0, 9'h011, 8, 0, 0, 0, 0, 0, 0);
    fifo_full = 1'b0;
    no_char("R5 full fifo discards");
    read_status(8'h40, "R5 overrun flag full");
    send(0, 9'h022, 8, 0, 0, 0, 0, 0, 1);
    send(0, 9'h033, 8, 0, 0, 0, 0, 0, 0);
    take_char(9'h022, "R5 waiting char kept");
    read_status(8'h40, "R5 overrun flag unaccepted");
    // R7 glitch
    rx = 1'b0;
    idle(OVS / 2 - 1);
    rx = 1'b1;
    idle(4 * OVS);
    no_char("R7 glitch");
    read_status(8'h00, "R7 glitch no flag");
    // R8 half duplex
    hd = 1'b1;
    tx_busy = 1'b1;
    send(0, 9'h077, 8, 0, 0, 0, 0, 0, 0);
    no_char("R8 masked while busy");
    read_status(8'h00, "R8 no flags");
    tx_busy = 1'b0;
    send(0, 9'h078, 8, 0, 0, 0, 0, 0, 1); take_char(9'h078, "R8 received when idle");
    hd = 1'b0;
    // R9 loopback
    loop_en = 1'b1;
    send(1, 9'h096, 8, 2, 0, 0, 0, 0, 1); take_char(9'h096, "R9 loopback char");
    send(0, 9'h055, 8, 0, 0, 0, 0, 0, 0);
    no_char("R9 pin ignored");
    read_status(8'h00, "R9 pin no flags");
    loop_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule